// File: doc/BRIEF.md
# Oversampled Phase-Picking Clock and Data Recovery

This block takes a serial line that has no clock of its own and turns it into retimed data bits. A multiphase front end, which is not part of this block, samples the line at eight evenly spaced points in every bit period. Each system clock cycle the block receives one bit period's worth of these samples as a vector. The block registers the samples into its own clock domain and looks for level changes between neighbouring samples. It builds a histogram of where in the bit period those changes fall.

At the end of each accumulation window the block finds the busiest edge position. It takes the position half a period away as its target and moves its sampling phase one step toward that target. The bit read at the chosen phase is presented with a valid strobe. When the sampling phase crosses the bit boundary, a pulse marks that one bit was dropped or doubled. The upstream line code must supply enough transitions; a window with no edges leaves the phase where it is.

Top module: `phase_pick_cdr`

## Requirements
- R1: `line_smp` carries one bit period per enabled cycle; bit k is the sample at phase k, with phase 0 the earliest. Samples are registered before any use, and `rx_bit` is the registered sample at the selected phase, appearing two clock edges after the vector is presented.
- R2: An edge at position k (1..7) is counted when sample k differs from sample k-1. An edge at position 0 is counted when sample 0 differs from sample 7 of the previous enabled period; that earlier sample is taken as 0 after reset.
- R3: Edge counts per position accumulate over WINDOW enabled periods (default 16). All counts clear when the window ends, and the phase can change only at a window end.
- R4: The target phase is (p + 4) mod 8, where p is the position with the highest count; on a tie the lowest position wins.
- R5: At a window end with at least one edge, the phase moves by exactly one step. It moves +1 when (target − phase) mod 8 is 1 to 4, −1 when it is 5 to 7, and not at all when it is 0. A window with no edges leaves the phase unchanged.
- R6: `slip_pulse` is high for one cycle when the phase steps from 7 to 0. `repeat_pulse` is high for one cycle when it steps from 0 to 7. The two pulses never occur together.
- R7: `rx_valid` stays low after reset until a window containing at least one edge has completed. From then on each enabled period yields one valid bit.
- R8: A cycle with `en` low is ignored. It adds no edges, does not advance the window, and produces no `rx_valid`.
- R9: During reset, `phase_sel` is 0 and `rx_bit`, `rx_valid`, `slip_pulse` and `repeat_pulse` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one bit period per enabled cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Marks `line_smp` as holding a new bit period |
| line_smp | input | NPH | Synchronised phase samples of one bit period, bit 0 earliest |
| rx_bit | output | 1 | Retimed data bit |
| rx_valid | output | 1 | `rx_bit` holds a new bit this cycle |
| phase_sel | output | $clog2(NPH) | Currently selected sampling phase |
| slip_pulse | output | 1 | Phase wrapped forward (7 to 0), one bit dropped |
| repeat_pulse | output | 1 | Phase wrapped backward (0 to 7), one bit doubled |

## Verification
Some rules are checked by assertions on every clock. The phase never jumps by more than one position. It changes only in the cycle after a window closes. Each wrap pulse matches the actual 7/0 crossing, and no edge count can exceed the number of periods elapsed in its window. Other behaviour is shown only by the bench scenarios, which lock onto lines with known edge offsets and compare against a reference model on every cycle. These cover convergence to the phase opposite the dominant edge, the lowest-position tie rule, both wrap directions, the late first valid after an edge-free start, and strobe counts through `en` gaps.

// File: rtl/cdr_pkg.sv
package cdr_pkg;
    // Direction of the single phase step allowed per window.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;
endpackage

// File: rtl/cdr_edge_scan.sv
// Marks the sample positions where the line changes level within one period.
module cdr_edge_scan #(
    parameter int NPH = 8
) (
    input  logic [NPH-1:0] smp,
    input  logic           prev_last,
    output logic [NPH-1:0] edges
);
    for (genvar k = 0; k < NPH; k++) begin : g_pos
        if (k == 0) begin : g_first
            // R2: position 0 compares with the last sample of the prior period
            assign edges[k] = smp[k] ^ prev_last;
        end else begin : g_rest
            assign edges[k] = smp[k] ^ smp[k-1];
        end
    end
endmodule

// File: rtl/cdr_edge_hist.sv
// Per-position edge counters over a window of enabled bit periods.
module cdr_edge_hist #(
    parameter int NPH    = 8,
    parameter int WINDOW = 16,
    parameter int CW     = $clog2(WINDOW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic [NPH-1:0]    edges,
    output logic [NPH*CW-1:0] tally,
    output logic              win_end,
    output logic              any_edge
);
    localparam int WC_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;

    typedef struct packed {
        logic [NPH-1:0][CW-1:0] cnt;
        logic [WC_W-1:0]        wc;
        logic                   seen;
    } hist_t;

    hist_t h_d, h_q;
    logic [NPH-1:0][CW-1:0] sum;

    always_comb begin
        h_d = h_q;
        for (int k = 0; k < NPH; k++) begin
            sum[k] = h_q.cnt[k] + CW'(edges[k]);
            tally[k*CW +: CW] = acc_en ? sum[k] : h_q.cnt[k];
        end
        win_end  = acc_en && (h_q.wc == WC_W'(WINDOW - 1));
        any_edge = h_q.seen || (acc_en && (|edges));
        if (acc_en) begin
            h_d.cnt  = sum;
            h_d.wc   = h_q.wc + WC_W'(1);
            h_d.seen = any_edge;
        end
        if (win_end) begin
            h_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    // R3: a count can never exceed the periods elapsed in the window
    for (genvar k = 0; k < NPH; k++) begin : g_chk
        assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
            32'(h_q.cnt[k]) <= 32'(h_q.wc));
    end

    assert_wc_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(h_q.wc) < WINDOW);
endmodule

// File: rtl/cdr_phase_pick.sv
// Chooses the next sampling phase from a completed edge histogram.
module cdr_phase_pick
    import cdr_pkg::*;
#(
    parameter int NPH  = 8,
    parameter int CW   = 5,
    parameter int PH_W = $clog2(NPH)
) (
    input  logic [NPH*CW-1:0] tally,
    input  logic [PH_W-1:0]   cur,
    output logic [PH_W-1:0]   nxt,
    output step_e             step
);
    localparam int HALF = NPH / 2;

    int best_idx;
    int best_val;
    int target;
    int diff;

    always_comb begin
        best_idx = 0;
        best_val = 0;
        for (int k = 0; k < NPH; k++) begin
            // strict compare keeps the lowest position on a tie (R4)
            if (int'(tally[k*CW +: CW]) > best_val) begin
                best_val = int'(tally[k*CW +: CW]);
                best_idx = k;
            end
        end
        target = (best_idx + HALF) % NPH;
        diff   = (target - int'(cur) + NPH) % NPH;
        if (diff == 0) begin
            step = STEP_HOLD;
            nxt  = cur;
        end else if (diff <= HALF) begin
            step = STEP_UP;
            nxt  = PH_W'((int'(cur) + 1) % NPH);
        end else begin
            step = STEP_DOWN;
            nxt  = PH_W'((int'(cur) + NPH - 1) % NPH);
        end
    end
endmodule

// File: rtl/phase_pick_cdr.sv
// Top: capture stage, edge histogram, phase choice and retimed output.
// NPH must be a power of two.
module phase_pick_cdr
    import cdr_pkg::*;
#(
    parameter int NPH    = 8,
    parameter int WINDOW = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic [NPH-1:0]         line_smp,
    output logic                   rx_bit,
    output logic                   rx_valid,
    output logic [$clog2(NPH)-1:0] phase_sel,
    output logic                   slip_pulse,
    output logic                   repeat_pulse
);
    localparam int PH_W = $clog2(NPH);
    localparam int CW   = $clog2(WINDOW + 1);

    typedef struct packed {
        logic [NPH-1:0]  smp;
        logic            enq;
        logic            prev;
        logic [PH_W-1:0] phase;
        logic            locked;
        logic            data;
        logic            valid;
        logic            slip;
        logic            rep;
    } cdr_t;

    cdr_t s_d, s_q;

    logic [NPH-1:0]    edges;
    logic [NPH*CW-1:0] tally;
    logic              win_end;
    logic              any_edge;
    logic [PH_W-1:0]   nxt_phase;
    step_e             step;

    cdr_edge_scan #(.NPH(NPH)) u_scan (
        .smp       (s_q.smp),
        .prev_last (s_q.prev),
        .edges     (edges)
    );

    cdr_edge_hist #(.NPH(NPH), .WINDOW(WINDOW), .CW(CW)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (s_q.enq),
        .edges    (edges),
        .tally    (tally),
        .win_end  (win_end),
        .any_edge (any_edge)
    );

    cdr_phase_pick #(.NPH(NPH), .CW(CW), .PH_W(PH_W)) u_pick (
        .tally (tally),
        .cur   (s_q.phase),
        .nxt   (nxt_phase),
        .step  (step)
    );

    always_comb begin
        s_d      = s_q;
        s_d.slip = 1'b0;
        s_d.rep  = 1'b0;
        s_d.enq  = en;
        if (en) begin
            s_d.smp = line_smp;
        end
        s_d.valid = s_q.enq && s_q.locked;
        if (s_q.enq) begin
            s_d.data = s_q.smp[s_q.phase];
            s_d.prev = s_q.smp[NPH-1];
        end
        if (win_end && any_edge) begin
            s_d.phase  = nxt_phase;
            s_d.locked = 1'b1;
            s_d.slip   = (step == STEP_UP)   && (s_q.phase == PH_W'(NPH - 1));
            s_d.rep    = (step == STEP_DOWN) && (s_q.phase == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rx_bit       = s_q.data;
    assign rx_valid     = s_q.valid;
    assign phase_sel    = s_q.phase;
    assign slip_pulse   = s_q.slip;
    assign repeat_pulse = s_q.rep;

    assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_sel != $past(phase_sel)) |->
            ((PH_W'(phase_sel - $past(phase_sel)) == PH_W'(1)) ||
             (PH_W'($past(phase_sel) - phase_sel) == PH_W'(1))));

    assert_move_at_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_sel != $past(phase_sel)) |-> $past(win_end));

    assert_slip_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        slip_pulse |-> (phase_sel == '0) && ($past(phase_sel) == PH_W'(NPH - 1)));

    assert_repeat_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        repeat_pulse |-> (phase_sel == PH_W'(NPH - 1)) && ($past(phase_sel) == '0));

    assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({slip_pulse, repeat_pulse}));

    assert_valid_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(en, 2));
endmodule

// File: tb/phase_pick_cdr_bench.sv
module phase_pick_cdr_bench;
    localparam int NPH = 8;
    localparam int WIN = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] line_smp = '0;
    logic       rx_bit, rx_valid, slip_pulse, repeat_pulse;
    logic [2:0] phase_sel;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    phase_pick_cdr #(.NPH(NPH), .WINDOW(WIN)) u_phase_pick_cdr (
        .clk(clk), .rst_n(rst_n), .en(en), .line_smp(line_smp),
        .rx_bit(rx_bit), .rx_valid(rx_valid), .phase_sel(phase_sel),
        .slip_pulse(slip_pulse), .repeat_pulse(repeat_pulse)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int         m_cnt[8];
    int         m_wc, m_phase, m_best, m_bv, m_tgt, m_diff;
    bit         m_seen, m_enq, m_prev, m_locked, m_data, m_valid, m_slip, m_rep;
    logic [7:0] m_smp;

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_cnt[i]) m_cnt[i] = 0;
            m_wc = 0; m_seen = 0; m_enq = 0; m_prev = 0; m_phase = 0;
            m_locked = 0; m_data = 0; m_valid = 0; m_slip = 0; m_rep = 0;
            m_smp = '0;
        end else begin
            m_slip = 0;
            m_rep  = 0;
            m_valid = m_enq && m_locked;
            if (m_enq) begin
                m_data = m_smp[m_phase];
                for (int k = 0; k < 8; k++) begin
                    if ((k == 0 ? (m_smp[0] ^ m_prev) : (m_smp[k] ^ m_smp[k-1])) == 1'b1) begin
                        m_cnt[k]++;
                        m_seen = 1;
                    end
                end
                m_prev = m_smp[7];
                m_wc++;
                if (m_wc == WIN) begin
                    if (m_seen) begin
                        m_best = 0; m_bv = 0;
                        for (int k = 0; k < 8; k++)
                            if (m_cnt[k] > m_bv) begin m_bv = m_cnt[k]; m_best = k; end
                        m_tgt  = (m_best + 4) % 8;
                        m_diff = (m_tgt - m_phase + 8) % 8;
                        if (m_diff >= 1 && m_diff <= 4) begin
                            m_slip  = (m_phase == 7);
                            m_phase = (m_phase + 1) % 8;
                        end else if (m_diff > 4) begin
                            m_rep   = (m_phase == 0);
                            m_phase = (m_phase + 7) % 8;
                        end
                        m_locked = 1;
                    end
                    foreach (m_cnt[i]) m_cnt[i] = 0;
                    m_wc = 0;
                    m_seen = 0;
                end
            end
            if (en) m_smp = line_smp;
            m_enq = en;
        end
    end

    // per-cycle comparison away from the active edge
    int  vcnt = 0;
    bit  vcount_on = 0;
    bit  slip_seen = 0, rep_seen = 0;
    always @(negedge clk) begin
        chk(rx_bit === m_data, "R1/R7 data", rx_bit, m_data);
        chk(rx_valid === m_valid, "R7 valid", rx_valid, m_valid);
        chk(int'(phase_sel) == m_phase, "R5 phase", phase_sel, m_phase);
        chk(slip_pulse === m_slip, "R6 slip", slip_pulse, m_slip);
        chk(repeat_pulse === m_rep, "R6 repeat", repeat_pulse, m_rep);
        if (slip_pulse) slip_seen = 1;
        if (repeat_pulse) rep_seen = 1;
        if (vcount_on && rx_valid) vcnt++;
    end

    // ---------------- stimulus ----------------
    bit        last_b = 0;
    logic [15:0] lfsr = 16'hACE1;

    function automatic bit next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // one bit period whose level change sits at sample position off (R2)
    task automatic period(input int off, input bit b, input bit e);
        @(negedge clk);
        for (int k = 0; k < 8; k++) line_smp[k] = (k < off) ? last_b : b;
        en = e;
        if (e) last_b = b;
    endtask

    task automatic run_windows(input int off, input int nwin);
        for (int i = 0; i < nwin * WIN; i++) period(off, next_rand(), 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(phase_sel == 3'd0 && !rx_valid && !rx_bit && !slip_pulse && !repeat_pulse,
            "R9 reset state", {rx_valid, phase_sel}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: an edge-free window does not lock the receiver
        for (int i = 0; i < WIN + 4; i++) period(0, 1'b0, 1'b1);
        @(negedge clk);
        chk(!rx_valid, "R7 no lock without edges", rx_valid, 0);
        chk(phase_sel == 3'd0, "R5 no move without edges", phase_sel, 0);

        // R2/R3/R4: edges at 6 -> target 2
        run_windows(6, 4);
        chk(phase_sel == 3'd2, "R4 converge off6", phase_sel, 2);
        // edges at 1 -> target 5
        run_windows(1, 5);
        chk(phase_sel == 3'd5, "R4 converge off1", phase_sel, 5);
        // edges at 4 -> target 0, passes through 7->0
        run_windows(4, 5);
        chk(phase_sel == 3'd0, "R5 converge off4", phase_sel, 0);
        chk(slip_seen, "R6 slip on forward wrap", slip_seen, 1);
        // edges at 2 -> target 6, passes through 0->7
        run_windows(2, 4);
        chk(phase_sel == 3'd6, "R5 converge off2", phase_sel, 6);
        chk(rep_seen, "R6 repeat on backward wrap", rep_seen, 1);

        // R8: en gaps; valid strobes must equal enabled periods
        for (int i = 0; i < 3; i++) period(2, 1'b0, 1'b0);
        vcnt = 0;
        vcount_on = 1;
        begin
            int nen;
            nen = 0;
            for (int i = 0; i < 12 * WIN; i++) begin
                bit e;
                e = (i % 2 == 0);
                if (e) nen++;
                period(6, e ? next_rand() : 1'b1, e);
            end
            period(6, 1'b0, 1'b0);
            period(6, 1'b0, 1'b0);
            @(negedge clk);
            vcount_on = 0;
            chk(vcnt == nen, "R8 strobes per enabled period", vcnt, nen);
        end
        chk(phase_sel == 3'd2, "R8 phase with gaps", phase_sel, 2);

        // R4 tie: alternating bits, edges split evenly between 1 and 3 -> target 5
        for (int i = 0; i < 6 * WIN; i++) period((i % 2 == 0) ? 1 : 3, ~last_b, 1'b1);
        chk(phase_sel == 3'd5, "R4 tie picks lowest", phase_sel, 5);

        repeat (3) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule